// File: doc/BRIEF.md
# 4B5B Receive Decoder with MII Output

This block sits between a receive path that already delivers aligned, descrambled 5-bit code groups (one per clock at 25 MHz in 100 Mbps operation) and the receive side of a Media Independent Interface. It watches the code-group stream for a start-of-stream pair. Inside a frame it translates each data code group to its 4-bit nibble, flags code groups that are not data, and recognises the end-of-stream pair. It drives the nibble data, data-valid, carrier-sense and receive-error outputs.

The decoding runs on the rising edge of the symbol clock. A separate stage moves the results to the outputs on the falling edge, so a controller can sample them on the next rising edge. To spot a two-symbol delimiter the block looks one symbol ahead, which adds one symbol of latency. A per-symbol bypass control skips the translation. The raw 5-bit code appears with its low four bits on the data nibble and its top bit on the error output. Frame tracking still drives data-valid and carrier sense as usual.

Top module: `rx4b5b_mii_dec`

## Requirements
- R1: Outside a frame, including after reset and during idle code groups 11111, data-valid, carrier sense and error stay low and the nibble output is 0000 whenever decoding is active (bypass low).
- R2: A code group 11000 followed at once by 10001 opens a frame. Both of these code groups come out as nibble 0101, with data-valid and carrier sense rising together on the first one. Data-valid always equals carrier sense.
- R3: A 11000 that is not followed at once by 10001 opens no frame and produces a deasserted output; a later 11000 10001 pair still opens a frame.
- R4: Inside a frame a data code group (written bit 4 down to bit 0) gives its nibble: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F, with data-valid high and error low.
- R5: Inside a frame, any code group that is not data gives error high, data-valid and carrier sense high and nibble 0000, and the frame continues. This covers 00100, a 01101 not followed by 00111, and a lone 00111.
- R6: Inside a frame, 01101 followed at once by 00111 closes it. Both code groups come out deasserted (data-valid, carrier sense, error low, nibble 0000).
- R7: Inside a frame, two consecutive 11111 code groups close it. The first gives error high with data-valid high and nibble 0000; the second is deasserted.
- R8: With bypass high for a code group, the nibble output carries its bits 3..0 and the error output carries its bit 4. Data-valid and carrier sense follow frame tracking as in decode mode. Bypass is sampled together with the code group it applies to.
- R9: Outputs change only on the falling clock edge. A code group sampled on rising edge k is reflected on the outputs after the falling edge that follows rising edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_i | input | 5 | Aligned, descrambled code group, sampled on the rising edge |
| bypass_i | input | 1 | Raw pass-through for the code group sampled with it |
| rxd_o | output | 4 | Receive nibble, updated on the falling edge |
| rx_dv_o | output | 1 | Receive data valid |
| crs_o | output | 1 | Carrier sense |
| rx_er_o | output | 1 | Receive error, or raw bit 4 in bypass |

## Verification
A wrong frame-tracking state shows on the ports within one or two symbol times. If it sticks in the frame state, data-valid stays high through idle, or idle gets flagged as an error. If it misses a start, the preamble nibbles never appear. If it drops out early, data-valid falls in mid-frame. A wrong lookahead shows as a one-symbol shift between delimiters and data-valid edges, and the per-symbol scoreboard compares every output in every cycle. A fault in the falling-edge stage shows as outputs that move between the falling sample and the next rising edge.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam sym_t CG_SSD1 = 5'b11000;
    localparam sym_t CG_SSD2 = 5'b10001;
    localparam sym_t CG_ESD1 = 5'b01101;
    localparam sym_t CG_ESD2 = 5'b00111;
    localparam sym_t CG_IDLE = 5'b11111;
    localparam nib_t PREAMBLE_NIB = 4'b0101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SSD2,
        ST_DATA,
        ST_ESD2
    } fstate_e;

    typedef struct packed {
        nib_t rxd;
        logic dv;
        logic crs;
        logic er;
    } mii_rx_t;

    typedef struct packed {
        fstate_e st;
        sym_t    sym;
        logic    byp;
        mii_rx_t out;
    } ctl_t;
endpackage

// File: rtl/rxdec_symbol_map.sv
module rxdec_symbol_map
    import rxdec_pkg::*;
(
    input  sym_t code_i,
    output logic is_data_o,
    output nib_t nib_o
);
    always_comb begin
        is_data_o = 1'b1;
        nib_o     = '0;
        unique case (code_i)
            5'b11110: nib_o = 4'h0;
            5'b01001: nib_o = 4'h1;
            5'b10100: nib_o = 4'h2;
            5'b10101: nib_o = 4'h3;
            5'b01010: nib_o = 4'h4;
            5'b01011: nib_o = 4'h5;
            5'b01110: nib_o = 4'h6;
            5'b01111: nib_o = 4'h7;
            5'b10010: nib_o = 4'h8;
            5'b10011: nib_o = 4'h9;
            5'b10110: nib_o = 4'hA;
            5'b10111: nib_o = 4'hB;
            5'b11010: nib_o = 4'hC;
            5'b11011: nib_o = 4'hD;
            5'b11100: nib_o = 4'hE;
            5'b11101: nib_o = 4'hF;
            default:  is_data_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxdec_frame_ctl.sv
module rxdec_frame_ctl
    import rxdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sym_t    sym_i,
    input  logic    byp_i,
    output mii_rx_t out_o
);
    localparam mii_rx_t MII_QUIET = '0;
    localparam ctl_t    CTL_RST   = '{st: ST_IDLE, sym: CG_IDLE, byp: 1'b0, out: MII_QUIET};

    ctl_t    ctl_d, ctl_q;
    logic    cur_is_data;
    nib_t    cur_nib;
    mii_rx_t mo;

    rxdec_symbol_map u_map (
        .code_i    (ctl_q.sym),
        .is_data_o (cur_is_data),
        .nib_o     (cur_nib)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.sym = sym_i;
        ctl_d.byp = byp_i;
        mo        = MII_QUIET;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.sym == CG_SSD1 && sym_i == CG_SSD2) begin
                    mo       = '{rxd: PREAMBLE_NIB, dv: 1'b1, crs: 1'b1, er: 1'b0};
                    ctl_d.st = ST_SSD2;
                end
            end
            ST_SSD2: begin
                mo       = '{rxd: PREAMBLE_NIB, dv: 1'b1, crs: 1'b1, er: 1'b0};
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (ctl_q.sym == CG_ESD1 && sym_i == CG_ESD2) begin
                    ctl_d.st = ST_ESD2;
                end else if (ctl_q.sym == CG_IDLE && sym_i == CG_IDLE) begin
                    mo       = '{rxd: '0, dv: 1'b1, crs: 1'b1, er: 1'b1};
                    ctl_d.st = ST_IDLE;
                end else if (cur_is_data) begin
                    mo = '{rxd: cur_nib, dv: 1'b1, crs: 1'b1, er: 1'b0};
                end else begin
                    mo = '{rxd: '0, dv: 1'b1, crs: 1'b1, er: 1'b1};
                end
            end
            ST_ESD2: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (ctl_q.byp) begin
            mo.rxd = ctl_q.sym[NIB_W-1:0];
            mo.er  = ctl_q.sym[SYM_W-1];
        end
        ctl_d.out = mo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign out_o = ctl_q.out;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.out.dv && !$past(ctl_q.byp)) |-> (ctl_q.out.rxd == '0 && !ctl_q.out.er));

    // R2
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_q.out.dv) && !$past(ctl_q.byp)) |-> ctl_q.out.rxd == PREAMBLE_NIB);

    // R6
    esd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ESD2) |=> !ctl_q.out.dv);

    // R5
    err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.out.er && !$past(ctl_q.byp)) |-> ctl_q.out.dv);
endmodule

// File: rtl/rxdec_fall_reg.sv
module rxdec_fall_reg
    import rxdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  mii_rx_t out_i,
    output mii_rx_t port_o
);
    mii_rx_t port_d, port_q;

    always_comb begin
        port_d = out_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign port_o = port_q;

    // R2
    crs_dv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_q.dv == port_q.crs);

    // R9
    rise_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $past(out_i) == out_i |=> port_q == $past(out_i));
endmodule

// File: rtl/rx4b5b_mii_dec.sv
module rx4b5b_mii_dec
    import rxdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_i,
    input  logic             bypass_i,
    output logic [NIB_W-1:0] rxd_o,
    output logic             rx_dv_o,
    output logic             crs_o,
    output logic             rx_er_o
);
    mii_rx_t dec_out;
    mii_rx_t port_out;

    rxdec_frame_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .sym_i (sym_i),
        .byp_i (bypass_i),
        .out_o (dec_out)
    );

    rxdec_fall_reg u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .out_i  (dec_out),
        .port_o (port_out)
    );

    assign rxd_o   = port_out.rxd;
    assign rx_dv_o = port_out.dv;
    assign crs_o   = port_out.crs;
    assign rx_er_o = port_out.er;
endmodule

// File: tb/rx4b5b_mii_dec_tb.sv
module rx4b5b_mii_dec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sym_i = 5'b11111;
    logic       bypass_i = 1'b0;
    logic [3:0] rxd_o;
    logic       rx_dv_o, crs_o, rx_er_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] rxd;
        logic       dv;
        logic       er;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t stage;
    bit   have_stage = 0;

    always #2 clk = ~clk;

    rx4b5b_mii_dec u_dut (
        .clk(clk), .rst_n(rst_n), .sym_i(sym_i), .bypass_i(bypass_i),
        .rxd_o(rxd_o), .rx_dv_o(rx_dv_o), .crs_o(crs_o), .rx_er_o(rx_er_o)
    );

    // R4 encoding as listed in the requirement
    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {rxd,dv,crs,er} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: one code group per cycle; expectation becomes due one symbol later (lookahead)
    task automatic send(input logic [4:0] s, input logic byp, input logic dv,
                        input logic [3:0] dec_rxd, input logic dec_er, input string tag);
        exp_t e;
        sym_i    = s;
        bypass_i = byp;
        @(posedge clk);
        if (have_stage) exp_q.push_back(stage);
        e.dv  = dv;
        e.rxd = byp ? s[3:0] : dec_rxd;
        e.er  = byp ? s[4]   : dec_er;
        e.tag = tag;
        stage = e;
        have_stage = 1;
        #1;
    endtask

    task automatic idles(input int n, input logic byp);
        for (int i = 0; i < n; i++) send(5'b11111, byp, 1'b0, 4'h0, 1'b0, "R1");
    endtask

    task automatic ssd(input logic byp);
        send(5'b11000, byp, 1'b1, 4'h5, 1'b0, "R2");
        send(5'b10001, byp, 1'b1, 4'h5, 1'b0, "R2");
    endtask

    task automatic esd(input logic byp);
        send(5'b01101, byp, 1'b0, 4'h0, 1'b0, "R6");
        send(5'b00111, byp, 1'b0, 4'h0, 1'b0, "R6");
    endtask

    task automatic data(input logic [3:0] n, input logic byp, input string tag);
        send(enc(n), byp, 1'b1, n, 1'b0, tag);
    endtask

    // Monitor: pop and compare after each falling edge, then confirm no change at the rising edge
    initial begin
        exp_t e;
        logic [6:0] last;
        wait (rst_n);
        forever begin
            @(negedge clk);
            #1;
            last = {rxd_o, rx_dv_o, crs_o, rx_er_o};
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.tag, last, {e.rxd, e.dv, e.dv, e.er});
            end
            @(posedge clk);
            #1;
            check("R9", {rxd_o, rx_dv_o, crs_o, rx_er_o}, last);
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", {rxd_o, rx_dv_o, crs_o, rx_er_o}, 7'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        idles(4, 1'b0);
        // R2 R4 R6: every data code group in one frame
        ssd(1'b0);
        for (int n = 0; n < 16; n++) data(n[3:0], 1'b0, "R4");
        esd(1'b0);
        idles(3, 1'b0);

        // R3: lone start symbol, then a doubled one
        send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b0, "R3");
        idles(2, 1'b0);
        send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b0, "R3");
        ssd(1'b0);
        data(4'hA, 1'b0, "R3");
        // R5: error code groups inside the frame
        send(5'b00100, 1'b0, 1'b1, 4'h0, 1'b1, "R5");
        data(4'h3, 1'b0, "R5");
        send(5'b01101, 1'b0, 1'b1, 4'h0, 1'b1, "R5");
        data(4'h7, 1'b0, "R5");
        send(5'b00111, 1'b0, 1'b1, 4'h0, 1'b1, "R5");
        send(5'b11111, 1'b0, 1'b1, 4'h0, 1'b1, "R5");
        data(4'hC, 1'b0, "R5");
        esd(1'b0);
        idles(2, 1'b0);

        // R7: frame closed by two idles
        ssd(1'b0);
        data(4'h9, 1'b0, "R7");
        send(5'b11111, 1'b0, 1'b1, 4'h0, 1'b1, "R7");
        send(5'b11111, 1'b0, 1'b0, 4'h0, 1'b0, "R7");
        idles(2, 1'b0);

        // R8: bypass frame with raw bits
        idles(2, 1'b1);
        ssd(1'b1);
        data(4'h2, 1'b1, "R8");
        data(4'hF, 1'b1, "R8");
        send(5'b00100, 1'b1, 1'b1, 4'h0, 1'b0, "R8");
        esd(1'b1);
        idles(2, 1'b1);
        // back to decode mode, next frame decodes normally
        idles(2, 1'b0);
        ssd(1'b0);
        data(4'h6, 1'b0, "R8");
        esd(1'b0);
        idles(4, 1'b0);

        wait (exp_q.size() == 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule